// File: doc/BRIEF.md
# DDR SDRAM Self-Refresh Sequencer

This block takes over the command and clock-enable pins of a DDR SDRAM to put the device into self-refresh and bring it back out. While it is idle, the main controller's command passes straight through with clock enable held high. On a sleep request the block drives one refresh command in the same cycle that it pulls clock enable low. It then keeps clock enable low and the command at NOP for as long as the device sleeps.

On a wake request the block waits until the system reports that the memory clock is stable. Only then does it raise clock enable. From that rise it drives NOPs for a fixed exit window. The window is the larger of the refresh-completion time (`T_XSNR` clocks) and the DLL relock time (`DLL_CYC` clocks, 200 by default). After the window it asserts a ready flag for one hand-over cycle and returns command control to the main controller.

States: `ST_ACTIVE` (pass-through), `ST_ENTER` (refresh with clock enable falling), `ST_IN_SR` (asleep), `ST_WAIT_CLK` (waiting for a stable clock), `ST_EXIT_NOP` (exit window), `ST_READY` (hand-over). Transitions:
- `ST_ACTIVE` goes to `ST_ENTER` on `sleep_req`.
- `ST_ENTER` goes to `ST_IN_SR` always.
- `ST_IN_SR` goes to `ST_WAIT_CLK` on a wake request, either new or held.
- `ST_WAIT_CLK` goes to `ST_EXIT_NOP` on `clk_stable`.
- `ST_EXIT_NOP` goes to `ST_READY` when the window counter expires.
- `ST_READY` goes to `ST_ACTIVE` always.

Top module: `selfref_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `mem_cke` is 1, `ready` is 1 and `mem_cmd` equals `host_cmd` in the same cycle.
- R2: A `sleep_req` seen while idle causes, in the next cycle, `mem_cmd` = 3'b001 (refresh, encoded {RAS_n,CAS_n,WE_n}) together with `mem_cke` = 0 and `ready` = 0.
- R3: From the cycle after the refresh until clock enable rises again, `mem_cke` stays 0 and `mem_cmd` is 3'b111 (NOP), whatever `host_cmd` is.
- R4: A `wake_req` that arrives in the refresh cycle is held. It is acted on once the device is asleep, so the block leaves `ST_IN_SR` after exactly one sleeping cycle without another request.
- R5: `mem_cke` rises only in the cycle after a cycle in which the block was waiting with `clk_stable` = 1. While `clk_stable` is 0 the block keeps waiting with `mem_cke` = 0.
- R6: From the cycle in which `mem_cke` rises, `mem_cmd` is NOP for max(`T_XSNR`,`DLL_CYC`) cycles (200 by default), with `mem_cke` = 1 and `ready` = 0.
- R7: The cycle that follows the exit window drives NOP with `mem_cke` = 1 and `ready` = 1. The cycle after that is idle again (R1).
- R8: `sleep_req` is ignored outside the idle state, and `wake_req` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Memory clock is stable and may be used |
| host_cmd | input | 3 | Command from the main controller, {RAS_n,CAS_n,WE_n} |
| mem_cmd | output | 3 | Command driven to the SDRAM |
| mem_cke | output | 1 | Clock enable driven to the SDRAM |
| ready | output | 1 | Main controller owns the command pins |

## Verification
The bench sends a wake request in the refresh cycle itself. A design that dropped it would stay asleep, and one that acted on it at once would raise clock enable before the refresh had been issued. The bench holds `clk_stable` low for random stretches while a wake is pending, so a design that raised clock enable early is caught at the rise. It drives random non-NOP host commands throughout the exit window, so an off-by-one window would leak a host command before 200 cycles had passed. It also raises sleep during the exit and wake while idle, so a design that honoured either request would leave the expected state sequence.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_ENTER    = 3'd1,
        ST_IN_SR    = 3'd2,
        ST_WAIT_CLK = 3'd3,
        ST_EXIT_NOP = 3'd4,
        ST_READY    = 3'd5
    } srx_state_e;

    localparam int CMD_W = 3;

    // {RAS_n, CAS_n, WE_n}
    localparam logic [CMD_W-1:0] CMD_NOP = 3'b111;
    localparam logic [CMD_W-1:0] CMD_REF = 3'b001;

    function automatic int srx_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srx_exit_timer.sv
module srx_exit_timer #(
    parameter int LOAD_VAL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LOAD_VAL + 1);

    logic [CNT_W-1:0] count;

    // The load value is one less than the window, because the loaded
    // cycle itself is the first cycle of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= CNT_W'(LOAD_VAL - 1);
        end else if (run && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign done = (count == '0);

endmodule

// File: rtl/srx_wake_hold.sv
module srx_wake_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wake_req,
    output logic pending
);
    // Remembers a wake seen while entering or asleep; cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (arm) begin
            pending <= pending | wake_req;
        end else begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_seen,
    input  logic       clk_stable,
    input  logic       timer_done,
    output srx_state_e state,
    output logic       timer_load,
    output logic       timer_run,
    output logic       wake_arm
);
    srx_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACTIVE:   if (sleep_req)  state_nxt = ST_ENTER;
            ST_ENTER:                    state_nxt = ST_IN_SR;
            ST_IN_SR:    if (wake_seen)  state_nxt = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_stable) state_nxt = ST_EXIT_NOP;
            ST_EXIT_NOP: if (timer_done) state_nxt = ST_READY;
            ST_READY:                    state_nxt = ST_ACTIVE;
            default:                     state_nxt = ST_ACTIVE;
        endcase
    end

    assign timer_load = (state == ST_WAIT_CLK) && clk_stable;
    assign timer_run  = (state == ST_EXIT_NOP);
    assign wake_arm   = (state == ST_ENTER) || (state == ST_IN_SR);

endmodule

// File: rtl/selfref_seq.sv
module selfref_seq
    import srx_pkg::*;
#(
    parameter int T_XSNR  = 10,
    parameter int DLL_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             clk_stable,
    input  logic [CMD_W-1:0] host_cmd,
    output logic [CMD_W-1:0] mem_cmd,
    output logic             mem_cke,
    output logic             ready
);
    localparam int EXIT_CYC = srx_max(T_XSNR, DLL_CYC);

    srx_state_e state;
    logic       timer_load;
    logic       timer_run;
    logic       timer_done;
    logic       wake_arm;
    logic       wake_pend;

    srx_wake_hold u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (wake_arm),
        .wake_req (wake_req),
        .pending  (wake_pend)
    );

    srx_exit_timer #(.LOAD_VAL(EXIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (timer_run),
        .done  (timer_done)
    );

    srx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_seen  (wake_pend | wake_req),
        .clk_stable (clk_stable),
        .timer_done (timer_done),
        .state      (state),
        .timer_load (timer_load),
        .timer_run  (timer_run),
        .wake_arm   (wake_arm)
    );

    always_comb begin
        mem_cmd = CMD_NOP;
        mem_cke = 1'b0;
        ready   = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                mem_cmd = host_cmd;
                mem_cke = 1'b1;
                ready   = 1'b1;
            end
            ST_ENTER: begin
                mem_cmd = CMD_REF;
            end
            ST_IN_SR, ST_WAIT_CLK: begin
                mem_cmd = CMD_NOP;
            end
            ST_EXIT_NOP: begin
                mem_cke = 1'b1;
            end
            ST_READY: begin
                mem_cke = 1'b1;
                ready   = 1'b1;
            end
            default: begin
                mem_cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
#(
    parameter int T_XSNR  = 10,
    parameter int DLL_CYC = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_stable,
    input logic [CMD_W-1:0] mem_cmd,
    input logic             mem_cke,
    input logic             ready
);
    localparam int EXIT_CYC = srx_max(T_XSNR, DLL_CYC);
    localparam int WIN_W    = $clog2(EXIT_CYC + 1) + 1;

    logic             cke_q;
    logic [WIN_W-1:0] since;
    logic             rise_now;
    logic [WIN_W-1:0] win_cur;

    assign rise_now = mem_cke && !cke_q;
    assign win_cur  = rise_now ? '0 : since;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
            since <= WIN_W'(EXIT_CYC);
        end else begin
            cke_q <= mem_cke;
            if (rise_now) begin
                since <= WIN_W'(1);
            end else if (since != WIN_W'(EXIT_CYC)) begin
                since <= since + 1'b1;
            end
        end
    end

    AST_ENTER_REF_WITH_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cke) |-> (mem_cmd == CMD_REF && !ready)); // R2

    AST_ASLEEP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cke && !$past(mem_cke)) |-> (mem_cmd == CMD_NOP)); // R3

    AST_RISE_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cke) |-> $past(clk_stable)); // R5

    AST_EXIT_WINDOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cke && win_cur < WIN_W'(EXIT_CYC)) |-> (mem_cmd == CMD_NOP && !ready)); // R6

    AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_cke); // R7

    AST_READY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(ready)) |-> (win_cur == WIN_W'(EXIT_CYC) && mem_cmd == CMD_NOP)); // R7

endmodule

bind selfref_seq srx_checker #(.T_XSNR(T_XSNR), .DLL_CYC(DLL_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_stable (clk_stable),
    .mem_cmd    (mem_cmd),
    .mem_cke    (mem_cke),
    .ready      (ready)
);

// File: tb/selfref_seq_tb.sv
`timescale 1ns/1ps
module selfref_seq_tb;

    localparam int EXIT = 200;
    localparam logic [2:0] NOP = 3'b111;
    localparam logic [2:0] REF = 3'b001;

    // model states
    localparam int M_ACT = 0, M_ENT = 1, M_SR = 2, M_WAIT = 3, M_EXN = 4, M_RDY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       clk_stable = 1'b0;
    logic [2:0] host_cmd = NOP;
    logic [2:0] mem_cmd;
    logic       mem_cke;
    logic       ready;

    int vectors = 0;
    int fails = 0;
    int m_state = M_ACT;
    int m_cnt = 0;
    bit m_pend = 1'b0;
    bit prev_cke = 1'b1;
    bit prev_stable = 1'b0;
    int since_rise = EXIT;
    bit done = 1'b0;

    always #4 clk = ~clk;

    selfref_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .clk_stable (clk_stable),
        .host_cmd   (host_cmd),
        .mem_cmd    (mem_cmd),
        .mem_cke    (mem_cke),
        .ready      (ready)
    );

    function automatic logic [2:0] exp_cmd(input int st, input logic [2:0] hc);
        if (st == M_ACT) return hc;
        if (st == M_ENT) return REF;
        return NOP;
    endfunction

    function automatic logic exp_cke(input int st);
        return (st == M_ACT) || (st == M_EXN) || (st == M_RDY);
    endfunction

    function automatic logic exp_rdy(input int st);
        return (st == M_ACT) || (st == M_RDY);
    endfunction

    function automatic string tag_of(input int st);
        case (st)
            M_ACT:         return "R1";
            M_ENT:         return "R2";
            M_SR, M_WAIT:  return "R3";
            M_EXN:         return "R6";
            default:       return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cyc(input logic s, input logic w, input logic cs,
                       input logic [2:0] hc, input string tag_in);
        string tag;
        logic [2:0] ec;
        logic ek, er;
        @(negedge clk);
        sleep_req = s; wake_req = w; clk_stable = cs; host_cmd = hc;
        #1;
        tag = (tag_in == "") ? tag_of(m_state) : tag_in;
        ec = exp_cmd(m_state, hc);
        ek = exp_cke(m_state);
        er = exp_rdy(m_state);
        check(tag, {mem_cmd, mem_cke, ready} == {ec, ek, er}, "{cmd,cke,ready}",
              int'({mem_cmd, mem_cke, ready}), int'({ec, ek, er}));
        // independent protocol checks
        if (mem_cke && !prev_cke) begin
            check("R5", prev_stable, "clk_stable before cke rise", 0, 1);
            since_rise = 0;
        end
        if (mem_cke && since_rise < EXIT)
            check("R6", mem_cmd == NOP, "cmd inside exit window", int'(mem_cmd), int'(NOP));
        if (since_rise < EXIT) since_rise++;
        prev_cke = mem_cke;
        prev_stable = (m_state == M_WAIT) && cs;
        // model step
        case (m_state)
            M_ACT:  begin m_pend = 1'b0; if (s) m_state = M_ENT; end
            M_ENT:  begin m_pend = m_pend | w; m_state = M_SR; end
            M_SR:   if (m_pend || w) begin m_state = M_WAIT; m_pend = 1'b0; end
            M_WAIT: if (cs) begin m_state = M_EXN; m_cnt = EXIT - 1; end
            M_EXN:  if (m_cnt == 0) m_state = M_RDY; else m_cnt--;
            default: m_state = M_ACT;
        endcase
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] rc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, pass-through of several host commands
        cyc(0, 0, 0, 3'b011, "R1");
        cyc(0, 0, 0, 3'b100, "R1");
        // R8: wake while idle is ignored
        cyc(0, 1, 1, 3'b101, "R8");
        cyc(0, 0, 0, 3'b010, "R8");
        // R2: sleep; R4: wake arrives in the refresh cycle, sleep repeated there (R8)
        cyc(1, 0, 0, 3'b000, "R2");
        cyc(1, 1, 0, 3'b000, "R4");
        cyc(0, 0, 0, 3'b000, "R4");   // asleep one cycle, held wake acts
        // R5: clock not stable yet, cke must stay low
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 3'b000, "R5");
        cyc(0, 0, 1, 3'b000, "R5");
        // R6/R7: exit window with hostile host commands and sleep requests (R8)
        for (int i = 0; i < EXIT; i++) cyc(i[0], 0, 0, 3'b000, "R6");
        cyc(1, 0, 0, 3'b000, "R7");
        cyc(0, 0, 0, 3'b110, "R1");
        // random traffic
        for (int i = 0; i < 20000; i++) begin
            rc = 3'($urandom);
            cyc(($urandom % 40) == 0, ($urandom % 12) == 0,
                ($urandom % 5) == 0, rc, "");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule